// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits on the 8-bit data, 16-bit address bus of a small CPU and steers its accesses to an external cartridge ROM and an external cartridge RAM. The ROM occupies 0x0000–0x7FFF and cannot be written. Any CPU write into that range is therefore taken as a control write. Which quarter of the range is written determines the effect: it can unlock or lock the external RAM, choose the ROM bank for the upper ROM window, choose the RAM bank, or do nothing.

The lower ROM window (0x0000–0x3FFF) is fixed on ROM bank 0. The upper window (0x4000–0x7FFF) shows the selected bank. A selected value of 0 is promoted to bank 1, so bank 0 can never appear in the upper window. The 8 kB RAM window at 0xA000–0xBFFF is translated through the RAM bank register. It is only reachable after the unlock byte 0x0A has been written to the enable range. While it is locked, reads there return 0xFF and writes produce no strobe. The block drives the physical ROM and RAM addresses and the chip selects, and it returns the read data to the CPU.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank register holds 1, the RAM bank register holds 0 and RAM is locked. A read of 0x4000 then gives rom_addr 0x04000, and a read of 0xA000 gives 0xFF with ram_cs low.
- R2: For cpu_addr in 0x0000–0x3FFF, rom_addr is {5'b0, cpu_addr[13:0]} and cpu_rdata equals rom_rdata.
- R3: A CPU write in 0x2000–0x3FFF loads cpu_wdata[4:0] into the ROM bank register. From the next cycle, for cpu_addr in 0x4000–0x7FFF, rom_addr is {bank, cpu_addr[13:0]}. For any address outside 0x4000–0x7FFF, rom_addr is {5'b0, cpu_addr[13:0]}.
- R4: A ROM bank register value of 0 is translated as bank 1 in the upper window. Value 1 also gives bank 1.
- R5: A CPU write in 0x4000–0x5FFF loads cpu_wdata[1:0] into the RAM bank register. ram_addr is always {ram bank, cpu_addr[12:0]}.
- R6: A CPU write of exactly 0x0A in 0x0000–0x1FFF unlocks RAM from the next cycle. A write of any other value there locks it.
- R7: While RAM is locked, accesses in 0xA000–0xBFFF keep ram_cs and ram_we low, and cpu_rdata reads 0xFF there.
- R8: While RAM is unlocked, ram_cs is high for a read or write in 0xA000–0xBFFF. ram_we is high only for the write. cpu_rdata equals ram_rdata there.
- R9: rom_cs is high only for a CPU read (cpu_rd high, cpu_wr low) in 0x0000–0x7FFF, so a write never reaches the ROM. A write in 0x6000–0x7FFF changes no register.
- R10: For addresses outside both the ROM and RAM windows, rom_cs and ram_cs stay low and cpu_rdata reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| cpu_rd | input | 1 | CPU read strobe for this cycle |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| rom_rdata | input | 8 | Data from the ROM |
| ram_rdata | input | 8 | Data from the RAM |
| rom_addr | output | 19 | Physical ROM address |
| rom_cs | output | 1 | ROM chip select |
| ram_addr | output | 15 | Physical RAM address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |

## Verification
The hardest case to reach from the ports is a bank register value of 0 while the RAM is unlocked. Two things must coincide there: the promotion of bank 0 to bank 1 in the upper window, and the RAM gating. Near-miss unlock values such as 0x1A or 0x0B must also re-lock the RAM, and the next access must show it locked. Directed sequences first write bank 0, then re-lock and unlock with adjacent values, then write to the ignored 0x6000 range. After each step they read back through both windows. A long random phase then biases its addresses toward the control ranges, so that lock, bank and access events interleave in arbitrary order. The bench's behavioural model is compared with every output on every cycle.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

  localparam int CPU_AW    = 16;
  localparam int DW        = 8;
  localparam int ROM_OFS_W = 14;
  localparam int RAM_OFS_W = 13;

  typedef enum logic [1:0] {
    WIN_FIXED  = 2'd0,
    WIN_SWITCH = 2'd1,
    WIN_XRAM   = 2'd2,
    WIN_NONE   = 2'd3
  } win_e;

  function automatic win_e win_of(input logic [2:0] top3);
    win_e w;
    case (top3)
      3'b000, 3'b001: w = WIN_FIXED;
      3'b010, 3'b011: w = WIN_SWITCH;
      3'b101:         w = WIN_XRAM;
      default:        w = WIN_NONE;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/cbc_rst_sync.sv
module cbc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/cbc_decode.sv
module cbc_decode
  import cbc_pkg::*;
(
  input  logic [2:0] addr_top,
  input  logic       cpu_wr,
  output win_e       win,
  output logic       key_we,
  output logic       rom_sel_we,
  output logic       ram_sel_we
);

  always_comb begin
    win        = win_of(addr_top);
    key_we     = 1'b0;
    rom_sel_we = 1'b0;
    ram_sel_we = 1'b0;
    if (cpu_wr) begin
      case (addr_top)
        3'b000:  key_we     = 1'b1;
        3'b001:  rom_sel_we = 1'b1;
        3'b010:  ram_sel_we = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
#(
  parameter int          ROM_BANK_W = 5,
  parameter int          RAM_BANK_W = 2,
  parameter logic [7:0]  UNLOCK_KEY = 8'h0A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  key_we,
  input  logic                  rom_sel_we,
  input  logic                  ram_sel_we,
  input  logic [DW-1:0]         wdata,
  output logic [ROM_BANK_W-1:0] rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_en
);

  localparam logic [ROM_BANK_W-1:0] ROM_RST = ROM_BANK_W'(1);

  logic [ROM_BANK_W-1:0] rom_d, rom_q;
  logic [RAM_BANK_W-1:0] ram_d, ram_q;
  logic                  en_d, en_q;

  always_comb begin
    rom_d = wdata[ROM_BANK_W-1:0];
    ram_d = wdata[RAM_BANK_W-1:0];
    en_d  = (wdata == UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_q <= ROM_RST;
      ram_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (rom_sel_we) rom_q <= rom_d;
      if (ram_sel_we) ram_q <= ram_d;
      if (key_we)     en_q  <= en_d;
    end
  end

  assign rom_bank = rom_q;
  assign ram_bank = ram_q;
  assign ram_en   = en_q;

endmodule

// File: rtl/cbc_xlate.sv
module cbc_xlate
  import cbc_pkg::*;
#(
  parameter int ROM_BANK_W = 5,
  parameter int RAM_BANK_W = 2,
  parameter bit REMAP_ZERO = 1'b1
) (
  input  win_e                            win,
  input  logic [ROM_OFS_W-1:0]            ofs,
  input  logic                            cpu_rd,
  input  logic                            cpu_wr,
  input  logic [ROM_BANK_W-1:0]           rom_bank,
  input  logic [RAM_BANK_W-1:0]           ram_bank,
  input  logic                            ram_en,
  input  logic [DW-1:0]                   rom_rdata,
  input  logic [DW-1:0]                   ram_rdata,
  output logic [ROM_BANK_W+ROM_OFS_W-1:0] rom_addr,
  output logic                            rom_cs,
  output logic [RAM_BANK_W+RAM_OFS_W-1:0] ram_addr,
  output logic                            ram_cs,
  output logic                            ram_we,
  output logic [DW-1:0]                   cpu_rdata
);

  logic [ROM_BANK_W-1:0] eff_bank;

  generate
    if (REMAP_ZERO) begin : g_remap
      always_comb eff_bank = (rom_bank == '0) ? ROM_BANK_W'(1) : rom_bank;
    end else begin : g_plain
      always_comb eff_bank = rom_bank;
    end
  endgenerate

  logic rom_win, ram_win;

  always_comb begin
    rom_win  = (win == WIN_FIXED) || (win == WIN_SWITCH);
    ram_win  = (win == WIN_XRAM);
    rom_addr = (win == WIN_SWITCH) ? {eff_bank, ofs} : {{ROM_BANK_W{1'b0}}, ofs};
    ram_addr = {ram_bank, ofs[RAM_OFS_W-1:0]};
    rom_cs   = rom_win && cpu_rd && !cpu_wr;
    ram_cs   = ram_win && ram_en && (cpu_rd || cpu_wr);
    ram_we   = ram_win && ram_en && cpu_wr;
    if (rom_win)                cpu_rdata = rom_rdata;
    else if (ram_win && ram_en) cpu_rdata = ram_rdata;
    else                        cpu_rdata = 8'hFF;
  end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
#(
  parameter int         ROM_BANK_W = 5,
  parameter int         RAM_BANK_W = 2,
  parameter logic [7:0] UNLOCK_KEY = 8'h0A,
  localparam int        ROM_AW     = ROM_BANK_W + ROM_OFS_W,
  localparam int        RAM_AW     = RAM_BANK_W + RAM_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  input  logic [7:0]        rom_rdata,
  input  logic [7:0]        ram_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_cs,
  output logic              ram_we
);

  logic                  rst_n_sync;
  win_e                  win;
  logic                  key_we, rom_sel_we, ram_sel_we;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic                  ram_en;

  cbc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cbc_decode u_dec (
    .addr_top   (cpu_addr[15:13]),
    .cpu_wr     (cpu_wr),
    .win        (win),
    .key_we     (key_we),
    .rom_sel_we (rom_sel_we),
    .ram_sel_we (ram_sel_we)
  );

  cbc_regs #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W),
    .UNLOCK_KEY (UNLOCK_KEY)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .key_we     (key_we),
    .rom_sel_we (rom_sel_we),
    .ram_sel_we (ram_sel_we),
    .wdata      (cpu_wdata),
    .rom_bank   (rom_bank),
    .ram_bank   (ram_bank),
    .ram_en     (ram_en)
  );

  cbc_xlate #(
    .ROM_BANK_W (ROM_BANK_W),
    .RAM_BANK_W (RAM_BANK_W),
    .REMAP_ZERO (1'b1)
  ) u_xl (
    .win       (win),
    .ofs       (cpu_addr[ROM_OFS_W-1:0]),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .ram_en    (ram_en),
    .rom_rdata (rom_rdata),
    .ram_rdata (ram_rdata),
    .rom_addr  (rom_addr),
    .rom_cs    (rom_cs),
    .ram_addr  (ram_addr),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .cpu_rdata (cpu_rdata)
  );

endmodule

// File: rtl/cbc_chk.sv
module cbc_chk #(
  parameter int         ROM_BANK_W = 5,
  parameter int         RAM_BANK_W = 2,
  parameter logic [7:0] UNLOCK_KEY = 8'h0A
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [15:0]                      cpu_addr,
  input logic [7:0]                       cpu_wdata,
  input logic                             cpu_wr,
  input logic                             cpu_rd,
  input logic [7:0]                       cpu_rdata,
  input logic [ROM_BANK_W+13:0]           rom_addr,
  input logic                             rom_cs,
  input logic                             ram_cs,
  input logic                             ram_we,
  input logic [ROM_BANK_W-1:0]            rom_bank,
  input logic [RAM_BANK_W-1:0]            ram_bank,
  input logic                             ram_en
);

  AST_LOWER_IS_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_BANK_W+13:14] == '0)); // R2

  AST_UPPER_NEVER_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && cpu_addr[15:14] == 2'b01) |-> (rom_addr[ROM_BANK_W+13:14] != '0)); // R4

  AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata != UNLOCK_KEY) |=> !ram_cs); // R6

  AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_en && cpu_addr[15:13] == 3'b101) |-> (cpu_rdata == 8'hFF && !ram_cs)); // R7

  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_cs && cpu_wr)); // R8

  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |-> !rom_cs); // R9

  AST_IGNORED_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15:13] == 3'b011) |=>
      ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en))); // R9

endmodule

bind cart_bank_ctrl cbc_chk #(
  .ROM_BANK_W (ROM_BANK_W),
  .RAM_BANK_W (RAM_BANK_W),
  .UNLOCK_KEY (UNLOCK_KEY)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_wr    (cpu_wr),
  .cpu_rd    (cpu_rd),
  .cpu_rdata (cpu_rdata),
  .rom_addr  (rom_addr),
  .rom_cs    (rom_cs),
  .ram_cs    (ram_cs),
  .ram_we    (ram_we),
  .rom_bank  (rom_bank),
  .ram_bank  (ram_bank),
  .ram_en    (ram_en)
);

// File: tb/cart_bank_ctrl_tb.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr, cpu_rd;
  logic [7:0]  cpu_rdata, rom_rdata, ram_rdata;
  logic [18:0] rom_addr;
  logic        rom_cs;
  logic [14:0] ram_addr;
  logic        ram_cs, ram_we;

  int total = 0;
  int bad   = 0;
  int m_rom;
  int m_ram;
  bit m_en;
  string force_tag = "";

  always #2.5 clk = ~clk;

  cart_bank_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
    .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rom_addr(rom_addr),
    .rom_cs(rom_cs), .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    string t;
    t = (force_tag != "") ? force_tag : tag;
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at t=%0t", t, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic [7:0] d, input bit w, input bit r);
    int ia, bank, e_rom, e_ram, e_rd;
    bit rom_win, ram_win, e_rcs, e_xcs, e_we;
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_wr    = w;
    cpu_rd    = r;
    rom_rdata = 8'($urandom);
    ram_rdata = 8'($urandom);
    #1;
    ia      = int'(a);
    rom_win = ia < 'h8000;
    ram_win = ia >= 'hA000 && ia < 'hC000;
    bank    = (m_rom == 0) ? 1 : m_rom;
    if (ia >= 'h4000 && ia < 'h8000) e_rom = bank * 16384 + (ia % 16384);
    else                             e_rom = ia % 16384;
    e_ram = m_ram * 8192 + (ia % 8192);
    e_rcs = rom_win && r && !w;
    e_xcs = ram_win && m_en && (r || w);
    e_we  = ram_win && m_en && w;
    if (rom_win)              e_rd = int'(rom_rdata);
    else if (ram_win && m_en) e_rd = int'(ram_rdata);
    else                      e_rd = 'hFF;
    if (ia < 'h4000)                 check("R2", "rom_addr", int'(rom_addr), e_rom);
    else if (m_rom <= 1 && rom_win)  check("R4", "rom_addr", int'(rom_addr), e_rom);
    else                             check("R3", "rom_addr", int'(rom_addr), e_rom);
    check("R5", "ram_addr", int'(ram_addr), e_ram);
    check("R9", "rom_cs", int'(rom_cs), int'(e_rcs));
    check(m_en ? "R8" : "R7", "ram_cs", int'(ram_cs), int'(e_xcs));
    check(m_en ? "R8" : "R7", "ram_we", int'(ram_we), int'(e_we));
    if (rom_win)      check("R2",  "cpu_rdata", int'(cpu_rdata), e_rd);
    else if (ram_win) check(m_en ? "R8" : "R7", "cpu_rdata", int'(cpu_rdata), e_rd);
    else              check("R10", "cpu_rdata", int'(cpu_rdata), e_rd);
    if (!ram_win && !rom_win) check("R10", "ram_cs", int'(ram_cs), 0);
    @(posedge clk);
    if (w) begin
      case (a[15:13])
        3'b000: m_en  = (d == 8'h0A);
        3'b001: m_rom = int'(d[4:0]);
        3'b010: m_ram = int'(d[1:0]);
        default: ;
      endcase
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_rom = 1; m_ram = 0; m_en = 1'b0;
    rst_n = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; cpu_wr = 1'b0; cpu_rd = 1'b0;
    rom_rdata = '0; ram_rdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) step(16'h8000, 8'h00, 1'b0, 1'b0);

    force_tag = "R1";
    step(16'h4000, 8'h00, 1'b0, 1'b1);
    step(16'hA000, 8'h00, 1'b0, 1'b1);
    step(16'hA123, 8'h55, 1'b1, 1'b0);
    force_tag = "";

    step(16'h0150, 8'h00, 1'b0, 1'b1);
    step(16'h3FFF, 8'h00, 1'b0, 1'b1);

    force_tag = "R3";
    step(16'h2000, 8'h05, 1'b1, 1'b0);
    step(16'h4ABC, 8'h00, 1'b0, 1'b1);
    step(16'h3FFF, 8'h1F, 1'b1, 1'b0);
    step(16'h7FFF, 8'h00, 1'b0, 1'b1);
    step(16'h2100, 8'hE3, 1'b1, 1'b0);
    step(16'h5000, 8'h00, 1'b0, 1'b1);
    force_tag = "R4";
    step(16'h2000, 8'h00, 1'b1, 1'b0);
    step(16'h4000, 8'h00, 1'b0, 1'b1);
    step(16'h2000, 8'h01, 1'b1, 1'b0);
    step(16'h6001, 8'h00, 1'b0, 1'b1);
    step(16'h2000, 8'h20, 1'b1, 1'b0);
    step(16'h4002, 8'h00, 1'b0, 1'b1);

    force_tag = "R6";
    step(16'h0000, 8'h0A, 1'b1, 1'b0);
    step(16'hA010, 8'h00, 1'b0, 1'b1);
    step(16'h1FFF, 8'h1A, 1'b1, 1'b0);
    step(16'hA010, 8'h00, 1'b0, 1'b1);
    step(16'h1000, 8'h0A, 1'b1, 1'b0);
    step(16'hB000, 8'h00, 1'b0, 1'b1);
    step(16'h0000, 8'h0B, 1'b1, 1'b0);
    step(16'hB000, 8'h77, 1'b1, 1'b0);
    step(16'h0000, 8'h0A, 1'b1, 1'b0);

    force_tag = "R5";
    step(16'h4000, 8'h03, 1'b1, 1'b0);
    step(16'hBFFF, 8'h00, 1'b0, 1'b1);
    step(16'h5FFF, 8'hFE, 1'b1, 1'b0);
    step(16'hA555, 8'h99, 1'b1, 1'b0);

    force_tag = "R9";
    step(16'h2000, 8'h07, 1'b1, 1'b0);
    step(16'h6000, 8'h00, 1'b1, 1'b0);
    step(16'h7FFF, 8'hFF, 1'b1, 1'b0);
    step(16'h4444, 8'h00, 1'b0, 1'b1);
    step(16'hA444, 8'h00, 1'b0, 1'b1);

    force_tag = "R10";
    step(16'hC000, 8'h00, 1'b0, 1'b1);
    step(16'h8000, 8'h12, 1'b1, 1'b0);
    step(16'hFF80, 8'h00, 1'b0, 1'b1);
    force_tag = "";

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int          k;
      k = int'($urandom_range(0, 9));
      a = 16'($urandom);
      if (k < 3)      a[15] = 1'b0;
      else if (k < 6) a[15:13] = 3'b101;
      d = (k == 0) ? 8'h0A : 8'($urandom);
      k = int'($urandom_range(0, 2));
      step(a, d, k == 1, k == 2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule